// File: doc/BRIEF.md
# Light-Load Duty-Cycle Shutdown Detector

This block sits on the secondary side of a forward converter's rectifier controller. It watches the synchronizing clock (`ck_in`, already synchronized to the tick clock). For every completed clock period it measures two tick counts: the ticks between consecutive rising edges, and the ticks during which the clock was high. From these it decides whether the two rectifier gate drivers may run.

When the measured duty cycle drops below a low threshold (14 % by default), the block raises `sleep` and drops `gate_en`. Both gates then stay off and the load current flows through the body diodes. This also covers burst-mode operation of the primary controller at very light load. The gates are enabled again only after a period whose duty cycle is above a high threshold (18 % by default). The comparisons are done by cross-multiplication of integer counts, so no divider is needed.

A stalled clock also shuts the gates off. This is detected when the period counter saturates. A `bypass` input selects the variant without shutdown, in which the gates always follow the clock.

Top module: `lightload_guard`

## Requirements
- R1: After reset, with `bypass` low, `sleep` is 1 and `gate_en` is 0.
- R2: A period is measured from one rising edge of `ck_in` to the next. P is the number of ticks in the period and H is the number of those ticks sampled high. If 100·H > WAKE_PCT·P (WAKE_PCT = 18), the rising edge that ends the period clears `sleep`, and the change is visible one clock after that edge.
- R3: If 100·H < SLEEP_PCT·P (SLEEP_PCT = 14), the rising edge that ends the period sets `sleep`, with the same one-clock timing.
- R4: If SLEEP_PCT·P ≤ 100·H ≤ WAKE_PCT·P, the state is kept. This holds in both directions and includes the exact 14 % and 18 % points.
- R5: The first rising edge after reset, or after a timeout, makes no decision. It only starts a measurement.
- R6: If the period counter reaches 2^CNT_W−1 ticks (4095 by default) without a rising edge, `sleep` is set on the next clock. With the clock held low after a rising edge, `sleep` rises 4095 clocks after that edge.
- R7: While `bypass` is 1, `gate_en` is 1 and `sleep` is 0 in the same cycle, whatever the duty cycle. Measurement continues underneath, so releasing `bypass` shows the state decided meanwhile.
- R8: With `bypass` low, `gate_en` is always the complement of `sleep`.
- R9: Between rising edges, and with no timeout, `sleep` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock for measurement |
| rst | input | 1 | Synchronous active-high reset |
| ck_in | input | 1 | Synchronized converter clock |
| bypass | input | 1 | 1 = no shutdown, gates always enabled |
| gate_en | output | 1 | Enable for both gate drivers |
| sleep | output | 1 | Light-load shutdown indication |

## Verification
A shutdown or wake decision is due one clock after the tick in which `ck_in` is first seen high. The bench drives each period tick by tick and samples at the falling clock edge right after that tick, so it reads the decision about the period just finished. At the last low tick of each period it samples again to confirm that nothing changed in between.

The timeout is checked at exactly 4094 and 4095 low ticks after a rising edge. The outputs under `bypass` are combinational, so they are sampled a fraction of a cycle after `bypass` changes.

// File: rtl/lightload_pkg.sv
package lightload_pkg;

    typedef enum logic {
        PWR_RUN   = 1'b0,
        PWR_SLEEP = 1'b1
    } pwr_state_e;

    // 100*on > pct*per, evaluated without a divider
    function automatic logic duty_exceeds(input int unsigned on_t,
                                          input int unsigned per_t,
                                          input int unsigned pct);
        return (on_t * 32'd100) > (per_t * pct);
    endfunction

    // 100*on < pct*per
    function automatic logic duty_under(input int unsigned on_t,
                                        input int unsigned per_t,
                                        input int unsigned pct);
        return (on_t * 32'd100) < (per_t * pct);
    endfunction

endpackage

// File: rtl/lightload_meter.sv
module lightload_meter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ck_in,
    output logic             rise,
    output logic             timeout,
    output logic [CNT_W-1:0] on_cnt,
    output logic [CNT_W-1:0] per_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             ck_d;
    logic [CNT_W-1:0] on_q;
    logic [CNT_W-1:0] per_q;

    assign rise    = ck_in & ~ck_d;
    assign timeout = (per_q == CNT_MAX) & ~rise;
    assign on_cnt  = on_q;
    assign per_cnt = per_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_d  <= 1'b0;
            on_q  <= '0;
            per_q <= '0;
        end else begin
            ck_d <= ck_in;
            if (rise) begin
                // the rising tick is the first tick of the new period and is high
                on_q  <= CNT_ONE;
                per_q <= CNT_ONE;
            end else begin
                if (per_q != CNT_MAX) per_q <= per_q + CNT_ONE;
                if (ck_in && on_q != CNT_MAX) on_q <= on_q + CNT_ONE;
            end
        end
    end

    // high-tick count never exceeds the period count (R2, R3)
    p_on_within_per_r2: assert property (@(posedge clk) disable iff (rst)
        on_q <= per_q);

    // a rising edge always restarts the period measurement (R5)
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        rise |=> (per_q == CNT_ONE) && (on_q == CNT_ONE));

endmodule

// File: rtl/lightload_judge.sv
module lightload_judge
    import lightload_pkg::*;
#(
    parameter int unsigned CNT_W     = 12,
    parameter int unsigned SLEEP_PCT = 14,
    parameter int unsigned WAKE_PCT  = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             timeout,
    input  logic [CNT_W-1:0] on_cnt,
    input  logic [CNT_W-1:0] per_cnt,
    output logic             sleep_q
);
    pwr_state_e st_q;
    logic       armed_q;
    logic       go_run;
    logic       go_sleep;

    assign go_run   = duty_exceeds(32'(on_cnt), 32'(per_cnt), WAKE_PCT);
    assign go_sleep = duty_under(32'(on_cnt), 32'(per_cnt), SLEEP_PCT);
    assign sleep_q  = (st_q == PWR_SLEEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= PWR_SLEEP;
            armed_q <= 1'b0;
        end else if (timeout) begin
            st_q    <= PWR_SLEEP;
            armed_q <= 1'b0;
        end else if (rise) begin
            armed_q <= 1'b1;
            if (armed_q) begin
                if (go_run)        st_q <= PWR_RUN;
                else if (go_sleep) st_q <= PWR_SLEEP;
            end
        end
    end

    // waking happens only at a rising edge with a valid measurement (R2, R5)
    p_wake_at_edge_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep_q) |-> $past(rise && armed_q));

    // entering sleep needs an edge decision or a timeout (R3)
    p_sleep_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_q) |-> $past(rise || timeout));

    // a saturated period forces shutdown (R6)
    p_timeout_sleep_r6: assert property (@(posedge clk) disable iff (rst)
        timeout |=> sleep_q);

    // no change between edges (R9)
    p_hold_between_r9: assert property (@(posedge clk) disable iff (rst)
        (!rise && !timeout) |=> $stable(sleep_q));

endmodule

// File: rtl/lightload_guard.sv
module lightload_guard #(
    parameter int unsigned CNT_W     = 12,
    parameter int unsigned SLEEP_PCT = 14,
    parameter int unsigned WAKE_PCT  = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic ck_in,
    input  logic bypass,
    output logic gate_en,
    output logic sleep
);
    logic             rise;
    logic             timeout;
    logic [CNT_W-1:0] on_cnt;
    logic [CNT_W-1:0] per_cnt;
    logic             sleep_q;

    lightload_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .ck_in   (ck_in),
        .rise    (rise),
        .timeout (timeout),
        .on_cnt  (on_cnt),
        .per_cnt (per_cnt)
    );

    lightload_judge #(
        .CNT_W     (CNT_W),
        .SLEEP_PCT (SLEEP_PCT),
        .WAKE_PCT  (WAKE_PCT)
    ) u_judge (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .timeout (timeout),
        .on_cnt  (on_cnt),
        .per_cnt (per_cnt),
        .sleep_q (sleep_q)
    );

    assign sleep   = sleep_q & ~bypass;
    assign gate_en = ~sleep_q | bypass;

    // leaving reset lands in shutdown (R1)
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !bypass) |-> (sleep && !gate_en));

    // outputs never both active or both idle (R7, R8)
    p_outputs_differ_r8: assert property (@(posedge clk) disable iff (rst)
        gate_en != sleep);

endmodule

// File: tb/lightload_guard_bench.sv
module lightload_guard_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic rst;
    logic ck;
    logic bypass;
    logic gate_en;
    logic sleep_o;

    int vectors = 0;
    int misses  = 0;
    bit armed_m;
    bit sleep_m;
    int prev_h;
    int prev_p;

    lightload_guard u_lightload_guard (
        .clk     (clk),
        .rst     (rst),
        .ck_in   (ck),
        .bypass  (bypass),
        .gate_en (gate_en),
        .sleep   (sleep_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input logic v);
        ck = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_outputs(input string tag);
        if (bypass) begin
            check("R7 gate_en in bypass", gate_en, 1'b1);
            check("R7 sleep in bypass", sleep_o, 1'b0);
        end else begin
            check(tag, sleep_o, sleep_m);
            check("R8 gate_en complement", gate_en, !sleep_m);
        end
    endtask

    // one clock period: h high ticks then l low ticks (l >= 1)
    task automatic cycle(input int h, input int l);
        string tag;
        tick(1'b1);
        if (!armed_m) tag = "R5 no decision on first edge";
        else if (100 * prev_h > 18 * prev_p) begin
            tag = "R2 wake";
            sleep_m = 1'b0;
        end else if (100 * prev_h < 14 * prev_p) begin
            tag = "R3 shutdown";
            sleep_m = 1'b1;
        end else tag = "R4 hysteresis hold";
        armed_m = 1'b1;
        check_outputs(tag);
        for (int i = 1; i < h; i++) tick(1'b1);
        for (int i = 0; i < l; i++) tick(1'b0);
        check_outputs("R9 stable between edges");
        prev_h = h;
        prev_p = h + l;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst = 1'b1; ck = 1'b0; bypass = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        armed_m = 1'b0; sleep_m = 1'b1; prev_h = 0; prev_p = 0;
        check("R1 sleep after reset", sleep_o, 1'b1);
        check("R1 gate_en after reset", gate_en, 1'b0);

        cycle(5, 5);
        cycle(5, 5);

        // sweep every on-time for small periods, from both preset states
        for (int p = 7; p <= 28; p++) begin
            for (int h = 1; h < p; h++) begin
                for (int pre = 0; pre < 2; pre++) begin
                    if (pre == 0) cycle(p / 2, p - p / 2);
                    else cycle(1, 9);
                    cycle(h, p - h);
                end
            end
        end

        // exact threshold points: 18 % and 14 % of 50 ticks
        cycle(1, 9);  cycle(9, 41); cycle(9, 41); cycle(5, 5);
        cycle(7, 43); cycle(7, 43); cycle(8, 42); cycle(1, 9);
        cycle(8, 42); cycle(10, 40); cycle(5, 5);

        // timeout with the clock held low
        cycle(5, 5);
        tick(1'b1);
        sleep_m = 1'b0;
        check("R2 wake before timeout", sleep_o, 1'b0);
        for (int i = 0; i < 4094; i++) tick(1'b0);
        check("R6 no timeout at 4094", sleep_o, 1'b0);
        tick(1'b0);
        check("R6 timeout at 4095", sleep_o, 1'b1);
        check("R6 gate_en off after timeout", gate_en, 1'b0);
        sleep_m = 1'b1; armed_m = 1'b0;
        cycle(5, 5);
        cycle(5, 5);

        // bypass: outputs forced while decisions continue underneath
        cycle(5, 5);
        bypass = 1'b1;
        #1;
        check("R7 gate_en on bypass entry", gate_en, 1'b1);
        cycle(1, 19); cycle(1, 19); cycle(1, 19);
        bypass = 1'b0;
        #1;
        check("R7 state after release", sleep_o, sleep_m);
        check("R7 sleep after release is set", sleep_o, 1'b1);
        @(negedge clk);
        cycle(5, 5);
        cycle(5, 5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule